// File: doc/BRIEF.md
# Interrupt Cause Aggregation Controller

This block gathers interrupt events from three sources (receive, transmit and miscellaneous) into one interrupt line. Each source has its own bank of 32 sticky cause bits. Software masks each bank bit by bit through write-one set and clear registers. For each bit, software also chooses whether reading the cause register clears it or whether it must write a 1 to that bit.

Above the banks sits a three-bit summary register. Each summary bit is the OR of one bank's unmasked pending causes. Reading the summary clears it, so it needs no acknowledge write. A software mask over the summary decides which banks may drive the output line. A handler reads the summary, masks the bank it serves, reads or clears that bank's causes, and then unmasks.

All registers sit on a simple synchronous port. A read returns its data one cycle after the read strobe. Bank `b` (0 = RX, 1 = TX, 2 = MISC) occupies word addresses `8*b` to `8*b+7`. The summary is at address 24 and its mask at address 25.

Top module: `irq_cause_hub`

## Requirements
- R1: After reset, all cause bits and clear-mode bits are 0, every bank mask and the summary mask are all ones, and `irq_o` is 0.
- R2: A 1 on an event input bit sets the matching cause bit on the next clock edge. The bit stays set until it is cleared as described in R4 or R5.
- R3: Writing offset 3 of a bank sets the mask bits written as 1. Writing offset 4 clears the mask bits written as 1. Bits written as 0 keep their value. Offset 5 reads the current mask.
- R4: For a cause bit whose clear-mode bit (offset 1) is 0, writing a 1 to that bit of the cause register (offset 0) clears it. Writing 0 leaves it unchanged. Writes have no effect on cause bits whose clear-mode bit is 1.
- R5: For a cause bit whose clear-mode bit is 1, a read of offset 0 returns the bit and clears it. Cause bits whose clear-mode bit is 0 are kept by such a read.
- R6: Offset 2 reads the cause bits ANDed with the inverted mask. Reads of offsets 2 and 5 change no state.
- R7: If an event sets a cause bit in the same cycle that a write or read clears it, the bit ends up set.
- R8: Summary bit 0 (RX), bit 1 (TX) and bit 2 (MISC) at address 24 each follow, one cycle late, the OR of that bank's unmasked cause bits. A bank whose mask was all ones in the previous cycle shows 0 in its summary bit.
- R9: A read of address 24 returns the summary and forces it to 0 for the following cycle. A read in that cycle returns 0. After that the summary follows R8 again.
- R10: Address 25 is the summary mask, readable and writable. `irq_o` is 1 one cycle after any summary bit `k` is 1 while bit `k` of the summary mask is 0, and is 0 otherwise.
- R11: Read data appears on `reg_rd_data` in the cycle after `reg_rd_en`, and is 0 in any other cycle. Offset 1 reads back the clear-mode bits. Offsets 3, 4, 6 and 7, and every address outside the map, read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | ADDR_W | Word address of the register access |
| reg_wr_en | input | 1 | Write strobe |
| reg_wr_data | input | DATA_W | Write data |
| reg_rd_en | input | 1 | Read strobe |
| reg_rd_data | output | DATA_W | Read data, one cycle after the strobe |
| rx_evt_i | input | DATA_W | RX event pulses |
| tx_evt_i | input | DATA_W | TX event pulses |
| misc_evt_i | input | DATA_W | Miscellaneous event pulses |
| irq_o | output | 1 | Interrupt output |

## Verification
Two functions can fall in the same cycle: an event pulse arriving at a cause bit, and a clear of that bit, either by a write-one to a write-to-clear bit or by a read of a clear-on-read bit. Directed steps drive both in one cycle for each clear mode. Random traffic then mixes sparse event pulses with writes and reads to every bank offset. A cycle model in the bench, built from the requirements, judges every read and the interrupt line in every cycle. The same model covers the analogous overlap at the summary level, where a summary read and a change in the pending causes share a cycle.

// File: rtl/irq_hub_pkg.sv
// Package: shared address layout of the interrupt cause aggregation controller.
// Assumes word addressing; each bank spans 2**OFF_W words.
package irq_hub_pkg;
    localparam int NBANK     = 3;
    localparam int OFF_W     = 3;
    localparam int OFF_CAUSE = 0;
    localparam int OFF_MODE  = 1;
    localparam int OFF_MCAUS = 2;
    localparam int OFF_MSET  = 3;
    localparam int OFF_MCLR  = 4;
    localparam int OFF_MVAL  = 5;
    localparam int PSD_ADDR  = NBANK << OFF_W;
    localparam int PMSK_ADDR = PSD_ADDR + 1;
endpackage

// File: rtl/irq_cause_bank.sv
// Module: one cause bank holding sticky cause bits, a per-bit clear mode and a mask.
// Assumes the parent decodes addresses and asserts at most one write strobe per cycle.
module irq_cause_bank #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] evt_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              wr_cause_i,
    input  logic              wr_mode_i,
    input  logic              wr_mset_i,
    input  logic              wr_mclr_i,
    input  logic              rd_cause_i,
    output logic [DATA_W-1:0] cause_o,
    output logic [DATA_W-1:0] mode_o,
    output logic [DATA_W-1:0] mask_o,
    output logic              live_o
);
    logic [DATA_W-1:0] cause_q, mode_q, mask_q, clr_vec;

    // Bits to clear this cycle: write-one on write-to-clear bits, read on clear-on-read bits.
    always_comb begin
        clr_vec = ({DATA_W{wr_cause_i}} & wdata_i & ~mode_q)
                | ({DATA_W{rd_cause_i}} & mode_q);
    end

    // Sticky cause bits; a new event wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) cause_q <= '0;
        else        cause_q <= (cause_q & ~clr_vec) | evt_i;
    end

    // Clear-mode register, plain read/write.
    always_ff @(posedge clk) begin
        if (!rst_n)         mode_q <= '0;
        else if (wr_mode_i) mode_q <= wdata_i;
    end

    // Mask register driven by write-one set and write-one clear strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) mask_q <= '1;
        else        mask_q <= (mask_q | ({DATA_W{wr_mset_i}} & wdata_i))
                            & ~({DATA_W{wr_mclr_i}} & wdata_i);
    end

    assign cause_o = cause_q;
    assign mode_o  = mode_q;
    assign mask_o  = mask_q;
    assign live_o  = |(cause_q & ~mask_q);

    p_event_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((cause_q & $past(evt_i)) == $past(evt_i)));
    p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_cause_i && !rd_cause_i) |=> ((cause_q & $past(cause_q)) == $past(cause_q)));
    p_w1c_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cause_i && evt_i == '0) |=> ((cause_q & $past(wdata_i & ~mode_q)) == '0));
    p_cor_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_cause_i && evt_i == '0) |=> ((cause_q & $past(mode_q)) == '0));
    p_mask_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mset_i |=> ((mask_q & $past(wdata_i)) == $past(wdata_i)));
    p_mask_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mclr_i |=> ((mask_q & $past(wdata_i)) == '0));
endmodule

// File: rtl/irq_cause_summary.sv
// Module: clear-on-read summary of the banks, its software mask and the registered output line.
// Assumes live_i bit k is the OR of bank k's unmasked causes.
module irq_cause_summary #(
    parameter int NBANK  = 3,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NBANK-1:0]  live_i,
    input  logic              rd_psd_i,
    input  logic              wr_pmask_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [NBANK-1:0]  psd_o,
    output logic [DATA_W-1:0] pmask_o,
    output logic              irq_o
);
    logic [NBANK-1:0]  psd_q;
    logic [DATA_W-1:0] pmask_q;
    logic              irq_q;

    // Summary register, forced to zero for one cycle by a read.
    always_ff @(posedge clk) begin
        if (!rst_n)        psd_q <= '0;
        else if (rd_psd_i) psd_q <= '0;
        else               psd_q <= live_i;
    end

    // Software mask over the summary bits.
    always_ff @(posedge clk) begin
        if (!rst_n)          pmask_q <= '1;
        else if (wr_pmask_i) pmask_q <= wdata_i;
    end

    // Registered interrupt line from the unblocked summary bits.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |(psd_q & ~pmask_q[NBANK-1:0]);
    end

    assign psd_o   = psd_q;
    assign pmask_o = pmask_q;
    assign irq_o   = irq_q;

    p_psd_cor_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_psd_i |=> (psd_q == '0));
    p_irq_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> $past(|(psd_q & ~pmask_q[NBANK-1:0])));
    p_irq_raise_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (|(psd_q & ~pmask_q[NBANK-1:0])) |=> irq_q);
endmodule

// File: rtl/irq_cause_hub.sv
// Module: top of the interrupt cause aggregation controller: address decode,
// three cause banks, summary stage and registered read port.
// Assumes one access per address per cycle; read data follows the strobe by one cycle.
module irq_cause_hub #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr_en,
    input  logic [DATA_W-1:0] reg_wr_data,
    input  logic              reg_rd_en,
    output logic [DATA_W-1:0] reg_rd_data,
    input  logic [DATA_W-1:0] rx_evt_i,
    input  logic [DATA_W-1:0] tx_evt_i,
    input  logic [DATA_W-1:0] misc_evt_i,
    output logic              irq_o
);
    import irq_hub_pkg::*;

    localparam int BIDX_W = ADDR_W - OFF_W;

    logic [BIDX_W-1:0] bank_idx;
    logic [OFF_W-1:0]  off;
    logic [DATA_W-1:0] evt_w   [NBANK];
    logic [DATA_W-1:0] cause_w [NBANK];
    logic [DATA_W-1:0] mode_w  [NBANK];
    logic [DATA_W-1:0] mask_w  [NBANK];
    logic [NBANK-1:0]  live_w;
    logic [NBANK-1:0]  psd_w;
    logic [DATA_W-1:0] pmask_w;
    logic [DATA_W-1:0] rd_mux, rd_q;
    logic              rd_psd, wr_pmask;

    assign bank_idx = reg_addr[ADDR_W-1:OFF_W];
    assign off      = reg_addr[OFF_W-1:0];
    assign evt_w[0] = rx_evt_i;
    assign evt_w[1] = tx_evt_i;
    assign evt_w[2] = misc_evt_i;
    assign rd_psd   = reg_rd_en && (reg_addr == ADDR_W'(PSD_ADDR));
    assign wr_pmask = reg_wr_en && (reg_addr == ADDR_W'(PMSK_ADDR));

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic sel;
        assign sel = (bank_idx == BIDX_W'(b));

        irq_cause_bank #(.DATA_W(DATA_W)) i_bank (
            .clk        (clk),
            .rst_n      (rst_n),
            .evt_i      (evt_w[b]),
            .wdata_i    (reg_wr_data),
            .wr_cause_i (sel && reg_wr_en && off == OFF_W'(OFF_CAUSE)),
            .wr_mode_i  (sel && reg_wr_en && off == OFF_W'(OFF_MODE)),
            .wr_mset_i  (sel && reg_wr_en && off == OFF_W'(OFF_MSET)),
            .wr_mclr_i  (sel && reg_wr_en && off == OFF_W'(OFF_MCLR)),
            .rd_cause_i (sel && reg_rd_en && off == OFF_W'(OFF_CAUSE)),
            .cause_o    (cause_w[b]),
            .mode_o     (mode_w[b]),
            .mask_o     (mask_w[b]),
            .live_o     (live_w[b])
        );

        p_masked_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
            psd_w[b] |-> !(&$past(mask_w[b])));
    end

    irq_cause_summary #(.NBANK(NBANK), .DATA_W(DATA_W)) i_summary (
        .clk        (clk),
        .rst_n      (rst_n),
        .live_i     (live_w),
        .rd_psd_i   (rd_psd),
        .wr_pmask_i (wr_pmask),
        .wdata_i    (reg_wr_data),
        .psd_o      (psd_w),
        .pmask_o    (pmask_w),
        .irq_o      (irq_o)
    );

    // Read multiplexer over bank offsets and the two summary registers.
    always_comb begin
        rd_mux = '0;
        for (int b = 0; b < NBANK; b++) begin
            if (bank_idx == BIDX_W'(b)) begin
                case (off)
                    OFF_W'(OFF_CAUSE): rd_mux = cause_w[b];
                    OFF_W'(OFF_MODE):  rd_mux = mode_w[b];
                    OFF_W'(OFF_MCAUS): rd_mux = cause_w[b] & ~mask_w[b];
                    OFF_W'(OFF_MVAL):  rd_mux = mask_w[b];
                    default:           rd_mux = '0;
                endcase
            end
        end
        if (reg_addr == ADDR_W'(PSD_ADDR))  rd_mux = DATA_W'(psd_w);
        if (reg_addr == ADDR_W'(PMSK_ADDR)) rd_mux = pmask_w;
    end

    // Registered read data, zero when no read was strobed.
    always_ff @(posedge clk) begin
        if (!rst_n)         rd_q <= '0;
        else if (reg_rd_en) rd_q <= rd_mux;
        else                rd_q <= '0;
    end

    assign reg_rd_data = rd_q;

    p_rd_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd_en |=> (reg_rd_data == '0));
endmodule

// File: tb/test_irq_cause_hub.sv
`timescale 1ns/1ps
module test_irq_cause_hub;
    localparam int DW = 32;
    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic          reg_wr_en = 1'b0;
    logic [DW-1:0] reg_wr_data = '0;
    logic          reg_rd_en = 1'b0;
    logic [DW-1:0] reg_rd_data;
    logic [DW-1:0] ev [3];
    logic          irq_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    irq_cause_hub #(.DATA_W(DW), .ADDR_W(AW)) i_irq_cause_hub (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr_en(reg_wr_en),
        .reg_wr_data(reg_wr_data), .reg_rd_en(reg_rd_en), .reg_rd_data(reg_rd_data),
        .rx_evt_i(ev[0]), .tx_evt_i(ev[1]), .misc_evt_i(ev[2]), .irq_o(irq_o)
    );

    // Model state built from the requirements.
    logic [DW-1:0] m_cause [3];
    logic [DW-1:0] m_mode  [3];
    logic [DW-1:0] m_mask  [3];
    logic [DW-1:0] m_pmask;
    logic [2:0]    m_psd;
    logic          m_irq;

    function automatic logic [DW-1:0] exp_read(input logic [AW-1:0] a);
        logic [DW-1:0] v = '0;
        if (a < 24) begin
            case (a[2:0])
                3'd0: v = m_cause[a[AW-1:3]];
                3'd1: v = m_mode[a[AW-1:3]];
                3'd2: v = m_cause[a[AW-1:3]] & ~m_mask[a[AW-1:3]];
                3'd5: v = m_mask[a[AW-1:3]];
                default: v = '0;
            endcase
        end else if (a == 24) v = DW'(m_psd);
        else if (a == 25) v = m_pmask;
        return v;
    endfunction

    function automatic string tag_of(input logic [AW-1:0] a);
        if (a == 24) return "R9";
        if (a == 25) return "R10";
        if (a >= 24) return "R11";
        case (a[2:0])
            3'd0: return "R5";
            3'd2: return "R6";
            3'd5: return "R3";
            default: return "R11";
        endcase
    endfunction

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One clock: drive at a falling edge, update the model at the rising edge, check at the next falling edge.
    task automatic step(input logic [AW-1:0] a, input bit we, input logic [DW-1:0] wd,
                        input bit re, input logic [DW-1:0] e0, input logic [DW-1:0] e1,
                        input logic [DW-1:0] e2, input string tag);
        logic [DW-1:0] rdv, clr;
        logic [2:0]    live;
        logic          irq_n;
        logic [DW-1:0] ei [3];
        ei[0] = e0; ei[1] = e1; ei[2] = e2;
        reg_addr = a; reg_wr_en = we; reg_wr_data = wd; reg_rd_en = re;
        ev[0] = e0; ev[1] = e1; ev[2] = e2;
        @(posedge clk);
        rdv = exp_read(a);
        for (int b = 0; b < 3; b++) live[b] = |(m_cause[b] & ~m_mask[b]);
        irq_n = |(m_psd & ~m_pmask[2:0]);
        m_psd = (re && a == 24) ? 3'b0 : live;
        m_irq = irq_n;
        for (int b = 0; b < 3; b++) begin
            clr = '0;
            if (we && a == AW'(8*b)) clr = clr | (wd & ~m_mode[b]);
            if (re && a == AW'(8*b)) clr = clr | m_mode[b];
            m_cause[b] = (m_cause[b] & ~clr) | ei[b];
            if (we && a == AW'(8*b+1)) m_mode[b] = wd;
            if (we && a == AW'(8*b+3)) m_mask[b] = m_mask[b] | wd;
            if (we && a == AW'(8*b+4)) m_mask[b] = m_mask[b] & ~wd;
        end
        if (we && a == 25) m_pmask = wd;
        @(negedge clk);
        reg_wr_en = 1'b0; reg_rd_en = 1'b0;
        ev[0] = '0; ev[1] = '0; ev[2] = '0;
        check("R10 irq", {31'b0, irq_o}, {31'b0, m_irq});
        if (re) check((tag == "") ? tag_of(a) : tag, reg_rd_data, rdv);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input string t);
        step(a, 1'b1, d, 1'b0, '0, '0, '0, t);
    endtask
    task automatic rd(input logic [AW-1:0] a, input string t);
        step(a, 1'b0, '0, 1'b1, '0, '0, '0, t);
    endtask
    task automatic idle();
        step('0, 1'b0, '0, 1'b0, '0, '0, '0, "");
    endtask

    initial begin
        ev[0] = '0; ev[1] = '0; ev[2] = '0;
        for (int b = 0; b < 3; b++) begin
            m_cause[b] = '0; m_mode[b] = '0; m_mask[b] = '1;
        end
        m_pmask = '1; m_psd = '0; m_irq = 1'b0;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values
        check("R1 irq", {31'b0, irq_o}, 32'd0);
        for (int b = 0; b < 3; b++) begin
            rd(AW'(8*b+5), "R1");
            rd(AW'(8*b+1), "R1");
            rd(AW'(8*b), "R1");
        end
        rd(AW'(25), "R1");

        // R2: events are sticky
        step('0, 1'b0, '0, 1'b0, 32'h0000_0011, 32'h8000_0000, 32'h0000_0400, "");
        idle();
        rd(AW'(0), "R2");
        rd(AW'(8), "R2");
        rd(AW'(16), "R2");

        // R3 / R6: mask set and clear, masked view, no side effects
        wr(AW'(4), 32'h0000_00FF, "");
        rd(AW'(5), "R3");
        rd(AW'(2), "R6");
        rd(AW'(2), "R6");
        wr(AW'(3), 32'h0000_000F, "");
        rd(AW'(5), "R3");

        // R8 / R10: summary and interrupt gating
        wr(AW'(25), ~32'h7, "");
        idle(); idle();
        rd(AW'(24), "R8");
        rd(AW'(24), "R9");
        rd(AW'(24), "R9");
        wr(AW'(3), 32'hFFFF_FFFF, "");
        idle(); idle();
        rd(AW'(24), "R8");

        // R4: write-one clear; writes to clear-on-read bits ignored
        wr(AW'(9), 32'h0000_FFFF, "");
        step('0, 1'b0, '0, 1'b0, '0, 32'h0001_0003, '0, "");
        wr(AW'(8), 32'hFFFF_FFFF, "");
        rd(AW'(8), "R4");

        // R5: clear-on-read only affects clear-on-read bits
        step('0, 1'b0, '0, 1'b0, '0, 32'h0003_0003, '0, "");
        rd(AW'(8), "R5");
        rd(AW'(8), "R5");

        // R7: event in the same cycle as a clear, both modes
        wr(AW'(16), '0, "");
        step(AW'(16), 1'b1, 32'h0000_0400, 1'b0, '0, '0, 32'h0000_0400, "");
        rd(AW'(17), "R7");
        step('0, 1'b0, '0, 1'b0, '0, '0, '0, "");
        wr(AW'(17), 32'h0000_0400, "");
        step(AW'(16), 1'b0, '0, 1'b1, '0, '0, 32'h0000_0400, "R7");
        rd(AW'(16), "R7");

        // R11: unmapped and write-only addresses read zero
        rd(AW'(3), "R11");
        rd(AW'(7), "R11");
        rd(AW'(30), "R11");

        // Random mix
        for (int i = 0; i < 3000; i++) begin
            logic [AW-1:0] a;
            logic [DW-1:0] e [3];
            int k = $urandom % 12;
            if (k < 9) a = AW'(8 * ($urandom % 3) + ($urandom % 8));
            else if (k < 11) a = AW'(24 + ($urandom % 2));
            else a = AW'(26 + $urandom % 38);
            for (int b = 0; b < 3; b++)
                e[b] = (($urandom % 4) == 0) ? (DW'(1) << ($urandom % DW)) : '0;
            step(a, ($urandom % 3) == 0, $urandom, ($urandom % 2) == 0, e[0], e[1], e[2], "");
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule